// File: doc/BRIEF.md
# RS485 Automatic Direction Controller

This block drives the direction of a half-duplex RS485 transceiver from the serial data a host sends, so the host does not need an RTS line. The raw host transmit bit is synchronised. When the line falls while the block is idle, it turns the line driver on and the receiver off. It then follows the character frame with a 16x oversample tick derived from a programmable baud divisor. The frame is one start bit, eight data bits and one stop bit.

When the stop bit ends, the block keeps the bus in transmit for a turnaround time chosen by a 2-bit switch value, and then releases it back to receive. If the start bit is no longer low at its middle, the event is treated as noise and the bus is released at once. If a new character starts during the turnaround hold, the driver stays on and a new frame is tracked. The data bit is forwarded unchanged, aligned with the enables. Only the direction pins are generated here.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: A high-to-low transition of `txd_in` while idle raises `drv_en` on the third rising clock edge after the input changes. No handshake input is used.
- R2: `rcv_en_n` is high in every cycle in which `drv_en` is high, so driver and receiver are never enabled together.
- R3: One oversample tick occurs every `baud_div` clocks, and a value of 0 acts as 1. A valid frame lasts 160 ticks. Falling edges inside the frame, such as those in the data bits, do not restart it.
- R4: After the frame, transmit is held for 16 << `turn_sel` ticks (`turn_sel` 0,1,2,3 gives 1,2,4,8 bit times). The total `drv_en` pulse is therefore (160 + 16<<`turn_sel`) * max(`baud_div`,1) clocks.
- R5: If the synchronised line is high at the 8th tick of a frame (mid start bit), the block returns to receive on that tick. The pulse is 8 * max(`baud_div`,1) clocks.
- R6: A falling edge during the turnaround hold restarts frame tracking without lowering `drv_en`.
- R7: During and after reset, `drv_en` is 0, `rcv_en_n` is 0 and `txd_out` is 1.
- R8: `txd_out` equals `txd_in` delayed by exactly three clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txd_in | input | 1 | Raw transmit data from the host |
| baud_div | input | DIV_W | Clocks per oversample tick (0 treated as 1) |
| turn_sel | input | SW_W | Turnaround select, hold = 1 << turn_sel bit times |
| drv_en | output | 1 | RS485 line driver enable, active high |
| rcv_en_n | output | 1 | RS485 receiver enable, active low |
| txd_out | output | 1 | Forwarded data bit to the transceiver |

## Verification
The bench uses the default parameters: a 16-bit divisor, 16x oversampling, eight data bits and a 2-bit turnaround select. It drives divisors of only 0 to 4, so a whole frame plus the longest 8-bit-time hold lasts a few hundred clocks. This puts every switch setting, the divide-by-zero case, the mid-bit noise rejection and a restart inside the hold window within a short run. Each pulse is measured to the exact clock, so an off-by-one tick in any count changes the result.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE  = 2'd0,
    DIR_FRAME = 2'd1,
    DIR_HOLD  = 2'd2
  } dir_state_t;
endpackage

// File: rtl/rs485_sync.sv
module rs485_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RST_VAL;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= RST_VAL;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rs485_tick_gen.sv
module rs485_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_c;
  logic             wrap_c;

  always_comb begin
    last_c = (div == '0) ? '0 : div - 1'b1;
    wrap_c = (cnt_q >= last_c);
  end

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (wrap_c)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && wrap_c;

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && run && div > 1 && $stable(div)) |=> !tick);
endmodule

// File: rtl/rs485_frame_fsm.sv
module rs485_frame_fsm
  import rs485_dir_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8,
  parameter int SW_W      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line,
  input  logic            fall,
  input  logic            tick,
  input  logic [SW_W-1:0] turn_sel,
  output logic            active,
  output logic            drv_en,
  output logic            rcv_dis
);
  localparam int FRAME_TICKS = OVS * (DATA_BITS + 2);
  localparam int MID_TICKS   = OVS / 2;
  localparam int MAX_HOLD    = OVS << ((1 << SW_W) - 1);
  localparam int CNT_MAX     = (FRAME_TICKS > MAX_HOLD) ? FRAME_TICKS : MAX_HOLD;
  localparam int TC_W        = $clog2(CNT_MAX + 1);
  localparam logic [TC_W-1:0] MID_LAST   = TC_W'(MID_TICKS - 1);
  localparam logic [TC_W-1:0] FRAME_LAST = TC_W'(FRAME_TICKS - 1);

  dir_state_t      state_q, state_n;
  logic [TC_W-1:0] tcnt_q, tcnt_n;
  logic [TC_W-1:0] hold_last;

  assign hold_last = TC_W'((OVS << turn_sel) - 1);

  always_comb begin
    state_n = state_q;
    tcnt_n  = tcnt_q;
    case (state_q)
      DIR_IDLE: begin
        if (fall) begin
          state_n = DIR_FRAME;
          tcnt_n  = '0;
        end
      end
      DIR_FRAME: begin
        if (tick) begin
          if (tcnt_q == MID_LAST && line) begin
            state_n = DIR_IDLE;
            tcnt_n  = '0;
          end else if (tcnt_q == FRAME_LAST) begin
            state_n = DIR_HOLD;
            tcnt_n  = '0;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
      end
      DIR_HOLD: begin
        if (fall) begin
          state_n = DIR_FRAME;
          tcnt_n  = '0;
        end else if (tick) begin
          if (tcnt_q == hold_last) begin
            state_n = DIR_IDLE;
            tcnt_n  = '0;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_n = DIR_IDLE;
        tcnt_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DIR_IDLE;
      tcnt_q  <= '0;
      drv_en  <= 1'b0;
      rcv_dis <= 1'b0;
    end else begin
      state_q <= state_n;
      tcnt_q  <= tcnt_n;
      drv_en  <= (state_n != DIR_IDLE);
      rcv_dis <= (state_n != DIR_IDLE);
    end
  end

  assign active = (state_q != DIR_IDLE);

  // R1
  start_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_IDLE && fall) |=> drv_en);

  // R5
  glitch_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_FRAME && tick && tcnt_q == MID_LAST && line) |=> !drv_en);

  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_HOLD && !fall && tick && tcnt_q == hold_last) |=> !drv_en);

  // R6
  restart_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DIR_HOLD && fall) |=> (drv_en && state_q == DIR_FRAME && tcnt_q == '0));
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int DIV_W     = 16,
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8,
  parameter int SW_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txd_in,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [SW_W-1:0]  turn_sel,
  output logic             drv_en,
  output logic             rcv_en_n,
  output logic             txd_out
);
  logic line_s;
  logic line_prev_q;
  logic fall;
  logic tick;
  logic active;
  logic fsm_drv;
  logic fsm_rcv_dis;

  rs485_sync #(.STAGES(2), .RST_VAL(1'b1)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (txd_in),
    .q   (line_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_prev_q <= 1'b1;
      txd_out     <= 1'b1;
    end else begin
      line_prev_q <= line_s;
      txd_out     <= line_s;
    end
  end

  assign fall = line_prev_q && !line_s;

  rs485_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .div  (baud_div),
    .tick (tick)
  );

  rs485_frame_fsm #(.OVS(OVS), .DATA_BITS(DATA_BITS), .SW_W(SW_W)) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .line     (line_s),
    .fall     (fall),
    .tick     (tick),
    .turn_sel (turn_sel),
    .active   (active),
    .drv_en   (fsm_drv),
    .rcv_dis  (fsm_rcv_dis)
  );

  assign drv_en   = fsm_drv;
  assign rcv_en_n = fsm_rcv_dis;

  // R2
  dir_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(drv_en && !rcv_en_n));

  // R2
  dir_follow_chk: assert property (@(posedge clk) disable iff (rst)
    drv_en == active);
endmodule

// File: tb/test_rs485_dir_ctrl.sv
module test_rs485_dir_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        txd;
  logic [15:0] baud_div;
  logic [1:0]  turn_sel;
  logic        drv_en, rcv_en_n, txd_out;

  int checks = 0, fails = 0;
  int run_len = 0, last_len = 0, pulses = 0;
  int overlaps = 0, mism = 0, nposed = 0;
  logic [2:0] hist = 3'b111;

  localparam int NV = 6;
  localparam int    VEC_DIV [NV] = '{2, 3, 1, 2, 0, 4};
  localparam int    VEC_SEL [NV] = '{0, 1, 2, 3, 0, 1};
  localparam int    VEC_GL  [NV] = '{0, 0, 0, 0, 0, 1};
  localparam int    VEC_EXP [NV] = '{352, 576, 224, 576, 176, 32};
  localparam string VEC_REQ [NV] = '{"R4", "R4", "R4", "R4", "R3", "R5"};

  always #5 clk = ~clk;

  rs485_dir_ctrl i_rs485_dir_ctrl (
    .clk(clk), .rst(rst), .txd_in(txd), .baud_div(baud_div),
    .turn_sel(turn_sel), .drv_en(drv_en), .rcv_en_n(rcv_en_n), .txd_out(txd_out)
  );

  always @(posedge clk) begin
    hist <= {hist[1:0], txd};
    if (rst) nposed <= 0; else nposed <= nposed + 1;
  end

  always @(negedge clk) begin
    if (drv_en && !rcv_en_n) overlaps++;
    if (!rst && nposed >= 3 && txd_out !== hist[2]) mism++;
    if (drv_en) run_len++;
    else if (run_len != 0) begin
      last_len = run_len;
      pulses++;
      run_len = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int bt, input logic [7:0] b);
    txd = 1'b0;
    repeat (bt) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      txd = b[k];
      repeat (bt) @(negedge clk);
    end
    txd = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic wait_pulse(input int p0);
    while (pulses == p0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    checks++;
    fails++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; txd = 1'b1; baud_div = 16'd2; turn_sel = 2'd0;
    repeat (5) @(negedge clk);
    // R7 during reset
    chk("R7", drv_en, 0);
    chk("R7", rcv_en_n, 0);
    chk("R7", txd_out, 1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R7 idle after reset
    chk("R7", drv_en, 0);
    chk("R7", txd_out, 1);

    // table walk: R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      int p0;
      int eff;
      baud_div = 16'(VEC_DIV[i]);
      turn_sel = 2'(VEC_SEL[i]);
      eff = (VEC_DIV[i] == 0) ? 1 : VEC_DIV[i];
      repeat (4) @(negedge clk);
      p0 = pulses;
      if (VEC_GL[i] != 0) begin
        txd = 1'b0;
        repeat (3) @(negedge clk);
        txd = 1'b1;
      end else begin
        send_frame(16 * eff, 8'h55 ^ 8'(i));
      end
      wait_pulse(p0);
      chk(VEC_REQ[i], last_len, VEC_EXP[i]);
      repeat (10) @(negedge clk);
    end

    // R1 latency and R2 during transmit
    begin
      int p0;
      baud_div = 16'd1; turn_sel = 2'd0;
      repeat (4) @(negedge clk);
      p0 = pulses;
      txd = 1'b0;
      @(negedge clk); chk("R1", drv_en, 0);
      @(negedge clk); chk("R1", drv_en, 0);
      @(negedge clk); chk("R1", drv_en, 1);
      chk("R2", rcv_en_n, 1);
      repeat (13) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        txd = k[0];
        repeat (16) @(negedge clk);
      end
      txd = 1'b1;
      wait_pulse(p0);
      chk("R3", last_len, 176);
    end

    // R6 restart inside turnaround hold
    begin
      int p0;
      baud_div = 16'd1; turn_sel = 2'd3;
      repeat (10) @(negedge clk);
      p0 = pulses;
      send_frame(16, 8'hA3);
      repeat (40) @(negedge clk);
      send_frame(16, 8'h3C);
      wait_pulse(p0);
      chk("R6", last_len, 488);
      repeat (5) @(negedge clk);
      chk("R6", pulses - p0, 1);
    end

    chk("R2", overlaps, 0);
    chk("R8", mism, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule